// File: doc/BRIEF.md
# Striped Bidirectional Rotate Unit

This block computes a generalized 32-bit rotate for a processor execute stage. It copies a 32-bit source word into both halves of a 64-bit working value. Five log-shifter stages then move bits down by 16, 8, 4, 2 and 1 places. At each bit position, a stage chooses between two independent shift amounts, and the first stage can invert the chosen amount in alternating 4-bit groups. With these controls the same network produces plain rotates and a family of byte and bit reorderings.

The three controls come from fixed fields of an instruction word. The low 32 bits of the final stage are sign-extended to a 64-bit register write value. A write-enable is raised only for a valid request whose destination field is nonzero. By default the result is registered, so there is one cycle of latency and a valid flag travels with the data.

Top module: `stripe_rotate_unit`

## Requirements
- R1: After reset, `out_valid`, `wr_en` and `wr_data` are all zero.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R3: `wr_en` is high one clock after a valid request only if that request's `dest` was nonzero. A request with `dest` equal to 0 gives no write, and `wr_en` is never high without `out_valid`.
- R4: The controls are decoded as follows. The primary amount `sh` is `insn[4:0]`. The secondary amount is `{insn[10:7],1'b0}`, so it is always even. The stripe flag is `insn[6]`. Bit 5 and bits 31:11 of `insn` have no effect on the result.
- R5: `wr_data[63:32]` always equals 32 copies of `wr_data[31]`.
- R6: When both amounts are equal and the stripe flag is 0, `wr_data[31:0]` is the source rotated right by that amount.
- R7: The stages use offsets 16, 8, 4, 2 and 1. They update bit indices up to 46, 38, 34, 32 and 31 respectively, and higher bits pass through unchanged. An updated bit i takes bit i+offset of the previous value when the selected amount has bit 4, 3, 2, 1 or 0 set respectively; otherwise it keeps its value. The amount is chosen by bit 3, 2, 1 or 0 of i in the first four stages: a 1 selects the primary amount and a 0 selects the secondary amount. The last stage always uses the primary amount.
- R8: Only in the 16-offset stage, when the stripe flag is 1 and bit 2 of i is 0, the selected amount is inverted before its bit 4 is tested.
- R9: `wr_data` holds its value in a cycle after one with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| src | input | 32 | Source word |
| insn | input | 32 | Instruction word carrying the rotate controls |
| dest | input | 5 | Destination register field |
| out_valid | output | 1 | Result valid |
| wr_en | output | 1 | Register write enable |
| wr_data | output | 64 | Sign-extended result |

## Verification
The hardest behaviour to reach from the ports is the mixed-amount, striped case. There the first stage inverts the amount in only some 4-bit lanes, and every stage mixes the two amounts bit by bit. A plain-rotate check cannot see errors in these paths. The stimulus therefore sweeps random source words against random instruction words with the stripe bit forced to 0 and to 1, with different primary and secondary amounts. Each result is compared with a bench-side bit-level model of the five stages. Directed vectors set unrelated instruction bits to show that they have no effect.

// File: rtl/rotx_pkg.sv
package rotx_pkg;
  localparam int SH_LSB     = 0;
  localparam int STRIPE_BIT = 6;
  localparam int SHX_LSB    = 7;
  localparam int GROUP_BIT  = 2;

  // Amount used at bit index idx of one stage.
  function automatic logic [4:0] lane_amount(input int idx, input int sel_bit,
                                              input bit stripe_en,
                                              input logic [4:0] sh,
                                              input logic [4:0] shx,
                                              input logic stp);
    logic [4:0] a;
    if (sel_bit < 0) a = sh;
    else a = (((idx >> sel_bit) & 1) != 0) ? sh : shx;
    if (stripe_en && stp && (((idx >> GROUP_BIT) & 1) == 0)) a = ~a;
    return a;
  endfunction

  function automatic logic [31:0] ror32(input logic [31:0] v, input logic [4:0] n);
    logic [63:0] d;
    d = {v, v} >> n;
    return d[31:0];
  endfunction
endpackage

// File: rtl/rotx_decode.sv
module rotx_decode #(
  parameter int IW = 32
) (
  input  logic [IW-1:0] insn,
  output logic [4:0]    sh,
  output logic [4:0]    shx,
  output logic          stp
);
  assign sh  = insn[rotx_pkg::SH_LSB +: 5];
  assign shx = {insn[rotx_pkg::SHX_LSB +: 4], 1'b0};
  assign stp = insn[rotx_pkg::STRIPE_BIT];

  logic unused_bits;
  assign unused_bits = ^{insn[IW-1:11], insn[5]};
endmodule

// File: rtl/rotx_stage.sv
module rotx_stage #(
  parameter int W       = 64,
  parameter int OFF     = 16,
  parameter int AMT_BIT = 4,
  parameter int SEL_BIT = 3,
  parameter bit STRIPE  = 1'b0,
  parameter int LIMIT   = 46
) (
  input  logic [W-1:0] din,
  input  logic [4:0]   sh,
  input  logic [4:0]   shx,
  input  logic         stp,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g <= LIMIT) begin : g_mv
      logic [4:0] amt;
      assign amt = rotx_pkg::lane_amount(g, SEL_BIT, STRIPE, sh, shx, stp);
      assign dout[g] = amt[AMT_BIT] ? din[g+OFF] : din[g];
    end else begin : g_keep
      assign dout[g] = din[g];
    end
  end
endmodule

// File: rtl/stripe_rotate_unit.sv
module stripe_rotate_unit #(
  parameter int XLEN    = 32,
  parameter int RW      = 64,
  parameter int IW      = 32,
  parameter int DW      = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   src,
  input  logic [IW-1:0] insn,
  input  logic [DW-1:0] dest,
  output logic          out_valid,
  output logic          wr_en,
  output logic [RW-1:0] wr_data
);
  localparam int WW  = 2 * XLEN;
  localparam int NST = $clog2(XLEN);

  logic [4:0] sh, shx;
  logic       stp;

  rotx_decode #(.IW(IW)) u_dec (.insn(insn), .sh(sh), .shx(shx), .stp(stp));

  logic [WW-1:0] chain [0:NST];
  assign chain[0] = {src, src};

  for (genvar k = 0; k < NST; k++) begin : g_stage
    rotx_stage #(
      .W      (WW),
      .OFF    (XLEN >> (k + 1)),
      .AMT_BIT(NST - 1 - k),
      .SEL_BIT(NST - 2 - k),
      .STRIPE (k == 0),
      .LIMIT  (XLEN - 2 + (XLEN >> (k + 1)))
    ) u_st (
      .din (chain[k]),
      .sh  (sh),
      .shx (shx),
      .stp (stp),
      .dout(chain[k+1])
    );
  end

  // Named internal events for the checker
  logic [RW-1:0] rot_result;
  logic          write_req;
  assign rot_result = {{(RW-XLEN){chain[NST][XLEN-1]}}, chain[NST][XLEN-1:0]};
  assign write_req  = in_valid && (dest != '0);

  logic unused_hi;
  assign unused_hi = ^chain[NST][WW-1:XLEN];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        wr_en     <= 1'b0;
        wr_data   <= '0;
      end else begin
        out_valid <= in_valid;
        wr_en     <= write_req;
        if (in_valid) wr_data <= rot_result;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign wr_en     = write_req;
    assign wr_data   = rot_result;
  end
endmodule

// File: rtl/stripe_rotate_checker.sv
module stripe_rotate_checker #(
  parameter int IW      = 32,
  parameter int DW      = 5,
  parameter int RW      = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   src,
  input logic [IW-1:0] insn,
  input logic [DW-1:0] dest,
  input logic          out_valid,
  input logic          wr_en,
  input logic [RW-1:0] wr_data
);
  logic       plain_rot;
  logic [4:0] amt;
  assign amt       = insn[4:0];
  assign plain_rot = in_valid && !insn[6] && (insn[4:0] == {insn[10:7], 1'b0});

  logic unused_chk;
  assign unused_chk = ^{insn[IW-1:11], insn[5]};

  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wr_data[RW-1:32] == {(RW-32){wr_data[31]}}));
  assert_en_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);

  if (REG_OUT) begin : g_seq
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_zero_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dest == '0) |=> !wr_en);
    assert_write_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dest != '0) |=> wr_en);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(wr_data));
    assert_plain_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      plain_rot |=> (wr_data[31:0] == rotx_pkg::ror32($past(src), $past(amt))));
  end
endmodule

bind stripe_rotate_unit stripe_rotate_checker #(
  .IW(IW), .DW(DW), .RW(RW), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .insn(insn),
  .dest(dest), .out_valid(out_valid), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/stripe_rotate_unit_test.sv
module stripe_rotate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src = '0;
  logic [31:0] insn = '0;
  logic [4:0]  dest = '0;
  logic        out_valid, wr_en;
  logic [63:0] wr_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stripe_rotate_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .insn(insn),
    .dest(dest), .out_valid(out_valid), .wr_en(wr_en), .wr_data(wr_data)
  );

  localparam int NV = 7;
  localparam logic [31:0] V_SRC [NV] = '{32'h12345678, 32'h80000001, 32'h12345678,
                                          32'h0000000F, 32'h00000001, 32'h12345678,
                                          32'h12345678};
  localparam logic [31:0] V_INS [NV] = '{32'h00000208, 32'h00000000, 32'h00000410,
                                          32'h00000104, 32'h0000079E, 32'hFFFFFA28,
                                          32'h0000F820};
  localparam logic [63:0] V_EXP [NV] = '{64'h0000000078123456, 64'hFFFFFFFF80000001,
                                          64'h0000000056781234, 64'hFFFFFFFFF0000000,
                                          64'h0000000000000004, 64'h0000000078123456,
                                          64'h0000000012345678};

  // Bench model: pairs of 64-bit vectors, stage by stage, bit by bit
  function automatic logic [63:0] model(input logic [31:0] s, input logic [31:0] w);
    logic [4:0]  p, q, a;
    logic        st;
    logic [63:0] cur, nxt;
    p = w[4:0]; q = {w[10:7], 1'b0}; st = w[6];
    cur = {s, s};
    for (int k = 0; k < 5; k++) begin
      int off = 16 >> k;
      nxt = cur;
      for (int i = 0; i <= 30 + off; i++) begin
        if (k == 4) a = p;
        else a = ((i >> (3 - k)) % 2 == 1) ? p : q;
        if (k == 0 && st && ((i / 4) % 2 == 0)) a = ~a;
        if (a[4-k]) nxt[i] = cur[i+off];
      end
      cur = nxt;
    end
    return {{32{cur[31]}}, cur[31:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] s, input logic [31:0] w, input logic [4:0] d);
    @(negedge clk);
    src = s; insn = w; dest = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (2) @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 wr_en", {63'd0, wr_en}, 64'd0);
    check("R1 wr_data", wr_data, 64'd0);
    rst_n = 1'b1;

    // Vector table: R6 plain rotates, R4 ignored bits, R5 sign extension
    for (int v = 0; v < NV; v++) begin
      issue(V_SRC[v], V_INS[v], 5'd3);
      check("R6/R4/R5 table", wr_data, V_EXP[v]);
      check("R2 valid", {63'd0, out_valid}, 64'd1);
      check("R3 write", {63'd0, wr_en}, 64'd1);
    end

    // R2 idle and R9 hold
    held = wr_data;
    @(negedge clk);
    check("R2 idle", {63'd0, out_valid}, 64'd0);
    src = 32'hDEADBEEF; insn = 32'h0000001F;
    @(negedge clk);
    check("R9 hold", wr_data, held);

    // R3 zero destination
    issue(32'hCAFEF00D, 32'h00000208, 5'd0);
    check("R3 no write", {63'd0, wr_en}, 64'd0);
    check("R3 valid", {63'd0, out_valid}, 64'd1);

    // R7 mixed amounts, stripe off; R8 stripe on
    for (int n = 0; n < 200; n++) begin
      logic [31:0] s, w;
      s = $urandom; w = $urandom;
      w[6] = (n >= 100);
      issue(s, w, 5'd1 + 5'(n % 31));
      check(w[6] ? "R8 stripe" : "R7 mixed", wr_data, model(s, w));
    end

    // R8 corner: stripe with all-zero / all-one amounts
    issue(32'h0F0F1234, 32'h00000040, 5'd7);
    check("R8 stripe zero amounts", wr_data, model(32'h0F0F1234, 32'h00000040));
    issue(32'hA5A5C3C3, 32'h000007DF, 5'd7);
    check("R8 stripe full amounts", wr_data, model(32'hA5A5C3C3, 32'h000007DF));

    // R2 back-to-back requests
    @(negedge clk);
    src = 32'h11111111; insn = 32'h00000208; dest = 5'd2; in_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", wr_data, 64'h0000000011111111);
    src = 32'h000000F0; insn = 32'h00000104;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", wr_data, 64'h000000000000000F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule